// File: doc/BRIEF.md
# Programmable-Oversampling Serial Bit Sampler

This block is the receive front end of an asynchronous serial port. It watches a raw receive line and recovers 8N1 frames: one start bit, eight data bits sent least significant bit first, and one stop bit. A baud generator outside the block supplies an oversample clock enable. The block counts a programmable number of enable pulses per bit period, from 7 to 16. Each bit is decided by a two-of-three majority vote over three consecutive oversample periods.

The first period of the voting window is set in one of two ways. In automatic mode it is derived from the oversampling ratio. In manual mode software supplies it, and the block limits it so that the whole window stays inside the bit. Each completed frame produces a one-cycle valid strobe and a held data byte. A stop bit that votes low sets a sticky framing-error flag. A registered interrupt output follows that flag while its enable input is high.

Top module: `uart_os_sampler`

## Requirements
- R1: The 4-bit rate code sets the oversample periods per bit. Codes 0 to 6 give 16 periods. Codes 7 to 15 give a number of periods equal to the code.
- R2: With the position-mode input at 0, the window starts at period floor(ratio/2)-2 and covers that period and the two after it, with periods counted from 0. This gives 7→1, 8/9→2, 10/11→3, 12/13→4, 14/15→5 and 16→6. The all-zero configuration therefore means 16× oversampling with the window at 6, 7 and 8.
- R3: With the position-mode input at 1, the window starts at the 4-bit programmed position.
- R4: A programmed position above ratio-3 is treated as ratio-3.
- R5: Each bit takes the value held by at least two of its three window samples. A single inverted sample inside the window has no effect. Line activity outside the window has no effect.
- R6: In idle, a falling edge of the synchronized line, seen on an oversample enable, marks period 0 of a start bit. If the start bit's vote reads 1, the block returns to idle with no strobe and no change to the data output.
- R7: After the start bit come 8 data bits, least significant first, placed so that the first data bit lands in bit 0 of the byte. One stop bit follows them.
- R8: A stop bit that votes 0 sets the framing-error flag. The flag stays at 1 until the clear input is high for a clock cycle. In that cycle, a new error has priority over the clear.
- R9: The error interrupt is registered. It equals the error-interrupt enable ANDed with the framing-error flag, and it changes on the same clock edge as the flag.
- R10: Every completed frame, including one with a framing error, raises the valid strobe for exactly one clock cycle. On that same edge the data output takes the received byte and then holds it until the next completed frame.
- R11: The synchronous active-high reset clears the data output, the strobe, the error flag and the interrupt. The receive line passes through a two-flop synchronizer before it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Raw asynchronous receive line |
| os_tick_i | input | 1 | Oversample clock enable, one pulse per oversample period |
| rate_code_i | input | 4 | Oversampling rate code |
| pos_manual_i | input | 1 | 0: automatic window position, 1: programmed position |
| pos_sel_i | input | 4 | Programmed window start period |
| err_irq_en_i | input | 1 | Error interrupt enable |
| err_clr_i | input | 1 | Clears the framing-error flag |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe per completed frame |
| frame_err_o | output | 1 | Sticky framing-error flag |
| err_irq_o | output | 1 | Gated error interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, a 4-bit rate code and a two-flop synchronizer. With these defaults all sixteen rate codes can be reached, covering every ratio from 7 to 16. Both position modes can be reached, including programmed positions of 0 and of 15, the second of which must be limited. The bench sends frames with random corruption outside the voting window and single-sample corruption inside it. A frame sent to a window placed wrongly or to a wrong ratio would then decode to a different byte. Directed frames flip two window samples, cut a start bit short and pull the stop bit low.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rx_state_t;
endpackage

// File: rtl/uos_sync.sv
module uos_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= RST_VAL;
        else       chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= {STAGES{RST_VAL}};
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uos_cfg_decode.sv
module uos_cfg_decode #(
  parameter int CODE_W   = 4,
  parameter int MIN_CODE = 7
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              manual_i,
  input  logic [CODE_W-1:0] pos_sel_i,
  output logic [CODE_W-1:0] last_o,
  output logic [CODE_W-1:0] pos_o
);
  localparam int MAX_RATIO = 2 ** CODE_W;
  localparam logic [CODE_W-1:0] MAX_LAST = CODE_W'(MAX_RATIO - 1);
  localparam logic [CODE_W-1:0] MAX_LIM  = CODE_W'(MAX_RATIO - 3);
  localparam logic [CODE_W-1:0] MAX_AUTO = CODE_W'(MAX_RATIO / 2 - 2);
  localparam logic [CODE_W-1:0] MINC     = CODE_W'(MIN_CODE);

  logic              use_max;
  logic [CODE_W-1:0] auto_pos;
  logic [CODE_W-1:0] limit_pos;

  always_comb begin
    use_max   = rate_code_i < MINC;
    last_o    = use_max ? MAX_LAST : rate_code_i - CODE_W'(1);
    limit_pos = use_max ? MAX_LIM  : rate_code_i - CODE_W'(3);
    auto_pos  = use_max ? MAX_AUTO : {1'b0, rate_code_i[CODE_W-1:1]} - CODE_W'(2);
    if (!manual_i)               pos_o = auto_pos;
    else if (pos_sel_i > limit_pos) pos_o = limit_pos;
    else                         pos_o = pos_sel_i;
  end

  p_window_fits_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ({1'b0, pos_o} + (CODE_W+1)'(2)) <= {1'b0, last_o});
  p_ratio_floor_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    last_o >= MINC - CODE_W'(1));
endmodule

// File: rtl/uos_vote.sv
module uos_vote (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic smp_en_i,
  input  logic bit_i,
  output logic maj_o
);
  logic [1:0] ones_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i)  ones_q <= 2'd0;
    else if (smp_en_i)   ones_q <= ones_q + {1'b0, bit_i};
  end

  assign maj_o = (ones_q >= 2'd2) || (ones_q == 2'd1 && bit_i);

  p_vote_cleared_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (ones_q == 2'd0));
endmodule

// File: rtl/uart_os_sampler.sv
module uart_os_sampler
  import uart_os_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 4,
  parameter int MIN_CODE    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rx_i,
  input  logic              os_tick_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              pos_manual_i,
  input  logic [CODE_W-1:0] pos_sel_i,
  input  logic              err_irq_en_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              frame_err_o,
  output logic              err_irq_o
);
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam logic [BIT_W-1:0] STOP_IDX = BIT_W'(DATA_W + 1);

  rx_state_t         state_q;
  logic              rx_s, rx_prev_q, fall_edge;
  logic [CODE_W-1:0] cnt_q, last_per, win_pos;
  logic [BIT_W-1:0]  bitn_q;
  logic [DATA_W-1:0] shift_q;
  logic              in_win, decide, bit_end, maj, vote_clr, vote_en;
  logic              stop_bad, err_next;

  uos_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(rx_i), .q_o(rx_s)
  );

  uos_cfg_decode #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE)) u_cfg (
    .clk_i(clk_i), .rst_i(rst_i),
    .rate_code_i(rate_code_i), .manual_i(pos_manual_i), .pos_sel_i(pos_sel_i),
    .last_o(last_per), .pos_o(win_pos)
  );

  always_comb begin
    fall_edge = rx_prev_q & ~rx_s;
    in_win    = (cnt_q >= win_pos) &&
                ({1'b0, cnt_q} <= ({1'b0, win_pos} + (CODE_W+1)'(2)));
    decide    = os_tick_i && (state_q == ST_RUN) &&
                ({1'b0, cnt_q} == ({1'b0, win_pos} + (CODE_W+1)'(2)));
    bit_end   = (cnt_q == last_per);
    vote_en   = os_tick_i && (state_q == ST_RUN) && in_win;
    vote_clr  = os_tick_i && ((state_q == ST_IDLE) || bit_end);
    stop_bad  = decide && (bitn_q == STOP_IDX) && !maj;
    err_next  = stop_bad ? 1'b1 : (err_clr_i ? 1'b0 : frame_err_o);
  end

  uos_vote u_vote (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(vote_clr),
    .smp_en_i(vote_en), .bit_i(rx_s), .maj_o(maj)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q     <= ST_IDLE;
      rx_prev_q   <= 1'b1;
      cnt_q       <= '0;
      bitn_q      <= '0;
      shift_q     <= '0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      frame_err_o <= 1'b0;
      err_irq_o   <= 1'b0;
    end else begin
      rx_valid_o  <= 1'b0;
      frame_err_o <= err_next;
      err_irq_o   <= err_next & err_irq_en_i;
      if (os_tick_i) begin
        rx_prev_q <= rx_s;
        if (state_q == ST_IDLE) begin
          if (fall_edge) begin
            state_q <= ST_RUN;
            cnt_q   <= CODE_W'(1);
            bitn_q  <= '0;
          end
        end else begin
          if (decide && bitn_q == '0 && maj) begin
            state_q <= ST_IDLE;
          end else if (decide && bitn_q == STOP_IDX) begin
            rx_data_o  <= shift_q;
            rx_valid_o <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            if (decide && bitn_q != '0)
              shift_q <= {maj, shift_q[DATA_W-1:1]};
            if (bit_end) begin
              cnt_q  <= '0;
              bitn_q <= bitn_q + BIT_W'(1);
            end else begin
              cnt_q <= cnt_q + CODE_W'(1);
            end
          end
        end
      end
    end
  end

  p_valid_single_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_valid_o |=> !rx_valid_o);
  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !rx_valid_o |-> $stable(rx_data_o));
  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    err_irq_o |-> frame_err_o);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (frame_err_o && !err_clr_i) |=> frame_err_o);
  p_valid_on_tick_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rx_valid_o) |-> $past(os_tick_i));
endmodule

// File: tb/test_uart_os_sampler.sv
`timescale 1ns/1ps
module test_uart_os_sampler;
  logic       clk = 1'b0;
  logic       rst;
  logic       rx, tick, man, en, clr;
  logic [3:0] rate, psel;
  logic [7:0] data;
  logic       valid, ferr, irq;

  int checks = 0, fails = 0, vcnt = 0;
  logic [7:0] exp_byte = 8'h00;
  logic       exp_err = 1'b0;

  always #2 clk = ~clk;

  uart_os_sampler i_uart_os_sampler (
    .clk_i(clk), .rst_i(rst), .rx_i(rx), .os_tick_i(tick),
    .rate_code_i(rate), .pos_manual_i(man), .pos_sel_i(psel),
    .err_irq_en_i(en), .err_clr_i(clr),
    .rx_data_o(data), .rx_valid_o(valid), .frame_err_o(ferr), .err_irq_o(irq)
  );

  always @(posedge clk) if (valid) vcnt++;

  function automatic int f_ratio(input int code);
    return (code < 7) ? 16 : code;
  endfunction

  function automatic int f_pos(input int code, input bit m, input int p);
    int r = f_ratio(code);
    if (!m) return r / 2 - 2;
    return (p > r - 3) ? r - 3 : p;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_period(input logic v);
    @(negedge clk); rx = v; tick = 1'b0;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // mode 0 clean, 1 random glitches, 2 stop bit low, 3 flip data bit 0
  task automatic send_frame(input logic [7:0] b, input int mode);
    int r, w, ones, flip_at;
    logic v, s, maj;
    bit inwin;
    r = f_ratio(rate);
    w = f_pos(rate, man, psel);
    for (int k = 0; k < 10; k++) begin
      v = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      ones = 0;
      flip_at = (mode == 1) ? $urandom_range(0, 3) : 3;
      for (int p = 0; p < r; p++) begin
        s = v;
        inwin = (p >= w) && (p <= w + 2);
        if (inwin) begin
          if (mode == 1 && p - w == flip_at && !(k == 0 && p == 0)) s = ~v;
          if (mode == 3 && k == 1 && p - w < 2) s = ~v;
          if (mode == 2 && k == 9 && p - w < 2) s = ~v;
          ones += int'(s);
        end else if (mode == 1 && !(k == 0 && p == 0) && !(k == 9 && p > w + 2)
                     && $urandom_range(0, 2) == 0) begin
          s = ~v;
        end
        drive_period(s);
      end
      maj = (ones >= 2);
      if (k >= 1 && k <= 8) exp_byte[k-1] = maj;
      if (k == 9 && !maj) exp_err = 1'b1;
    end
    repeat (3) drive_period(1'b1);
  endtask

  task automatic frame_check(input logic [7:0] b, input int mode, input string tag);
    int v0 = vcnt;
    send_frame(b, mode);
    chk(vcnt - v0 == 1, {tag, " valid strobe count R10"}, vcnt - v0, 1);
    chk(data == exp_byte, {tag, " data"}, data, exp_byte);
    chk(ferr == exp_err, {tag, " error flag R8"}, ferr, exp_err);
    chk(irq == (exp_err & en), {tag, " irq R9"}, irq, exp_err & en);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    int v0;
    void'($urandom(32'd20240611));
    rst = 1'b1; rx = 1'b1; tick = 1'b0; man = 1'b0; en = 1'b0; clr = 1'b0;
    rate = 4'd0; psel = 4'd6;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(data == 8'h00, "R11 data after reset", data, 0);
    chk(!valid && !ferr && !irq, "R11 flags after reset", {valid, ferr, irq}, 0);
    repeat (3) drive_period(1'b1);

    // R1 R2 R7 default 16x automatic
    frame_check(8'hA5, 0, "R1 R2 R7 default");
    frame_check(8'h01, 0, "R7 lsb first");
    frame_check(8'h80, 0, "R7 msb last");

    // R1 R2 R5 every rate code, automatic, glitches
    for (int c = 0; c < 16; c++) begin
      rate = 4'(c);
      frame_check(8'($urandom), 1, "R1 R2 R5 rate sweep");
    end

    // R3 R4 programmed positions including 0 and over limit
    man = 1'b1;
    foreach (psel[i]) ;
    for (int c = 7; c < 17; c += 3) begin
      rate = (c == 16) ? 4'd0 : 4'(c);
      for (int p = 0; p < 16; p += 5) begin
        psel = 4'(p);
        frame_check(8'($urandom), 1, "R3 R4 programmed position");
      end
    end
    rate = 4'd9; psel = 4'd15;
    frame_check(8'h3C, 1, "R4 clamp at limit");

    // R5 two flipped window samples flip the bit
    man = 1'b0; rate = 4'd12;
    frame_check(8'h00, 3, "R5 double flip");
    chk(data[0] == 1'b1, "R5 flipped bit value", data[0], 1);

    // R6 short start pulse rejected
    held = data;
    v0 = vcnt;
    drive_period(1'b0);
    repeat (40) drive_period(1'b1);
    chk(vcnt == v0, "R6 false start no strobe", vcnt - v0, 0);
    chk(data == held, "R6 false start data unchanged", data, held);
    frame_check(8'h5A, 0, "R6 recovery");

    // R8 R9 framing error, sticky, gated interrupt
    en = 1'b0;
    frame_check(8'hC3, 2, "R8 stop low");
    chk(ferr == 1'b1, "R8 error set", ferr, 1);
    @(negedge clk); en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(irq == 1'b1, "R9 irq after enable", irq, 1);
    frame_check(8'h77, 0, "R8 sticky over good frame");
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; exp_err = 1'b0;
    @(negedge clk);
    chk(ferr == 1'b0 && irq == 1'b0, "R8 R9 cleared", {ferr, irq}, 0);

    // R10 data held while idle
    held = data;
    repeat (20) drive_period(1'b1);
    chk(data == held, "R10 data held", data, held);

    // random mix
    for (int n = 0; n < 30; n++) begin
      rate = 4'($urandom_range(0, 15));
      man = 1'($urandom_range(0, 1));
      psel = 4'($urandom_range(0, 15));
      frame_check(8'($urandom), 1, "R1 R3 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule